// File: doc/BRIEF.md
# Binary to Packed Decimal Store Sequencer

This block turns an unsigned binary magnitude with a separate sign flag into a ten-byte packed-decimal image and hands it out as a sequence of byte writes. A single start pulse loads the sign and the magnitude. The block then extracts decimal digits from the low end upward. Each digit is the remainder of dividing the running value by ten, and the quotient becomes the new running value. A bit-serial restoring divider does the division, one quotient bit per clock.

Two digits are packed into each of the first nine bytes. The tenth byte carries one further digit and the sign. Each byte leaves on a one-cycle write strobe, with an offset that climbs from 0 to 9. A one-cycle done pulse ends the run. Values that need more than nineteen decimal digits are outside the block's range.

Top module: `bcd_store`

## Requirements
- R1: When the sign input is 1 at start, bit 7 of byte 9 is 1; when it is 0, that bit is 0. In both cases the digits come from the magnitude alone.
- R2: Each byte at offsets 0 to 8 holds two decimal digits: the less significant digit in bits 3:0 and the next more significant digit in bits 7:4.
- R3: Digits are emitted least significant first, so byte k (k from 0 to 8) holds decimal digits 2k and 2k+1 of the magnitude.
- R4: Byte 9 holds decimal digit 18 in bits 3:0, and bits 6:4 are zero.
- R5: Every run writes exactly ten bytes, at offsets 0,1,...,9 in increasing order, and each write strobe is high for exactly one cycle.
- R6: Done is high for exactly one cycle, in the cycle right after the write of byte 9.
- R7: With D = MAG_W+2, counting clock edges after the edge that samples start, byte k (k<9) is presented after edge 2D(k+1), byte 9 after edge 19D, and done after edge 19D+1.
- R8: A start pulse that arrives while a run is in progress is ignored. The bytes written are those of the run already under way.
- R9: Busy is 1 from the edge that accepts start until done is presented, and it is 0 in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; sampled only when idle |
| sign_in | input | 1 | Sign flag of the value (1 = negative) |
| mag_in | input | MAG_W | Unsigned magnitude |
| busy | output | 1 | Conversion in progress |
| wr_valid | output | 1 | Byte write strobe, one cycle per byte |
| wr_addr | output | ADDR_W | Byte offset of the current write |
| wr_data | output | 8 | Packed byte |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each digit costs MAG_W+2 cycles: one launch cycle, a load edge, MAG_W divide steps and a capture edge. Byte k is therefore due 2(MAG_W+2)(k+1) edges after start, byte 9 is due 19(MAG_W+2) edges after start, and done is due one edge after byte 9. The bench counts edges from the one that samples start, samples the outputs on the falling edge, and compares the edge count of every write and of the done pulse with these figures. The expected bytes come from decimal arithmetic in the bench, applied to the same magnitude and sign.

// File: rtl/bcd_store_pkg.sv
package bcd_store_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bcd_div10.sv
module bcd_div10 #(
  parameter int VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [VAL_W-1:0] dividend,
  output logic             done,
  output logic [VAL_W-1:0] quotient,
  output logic [3:0]       remainder
);
  localparam int CW = $clog2(VAL_W);

  logic [VAL_W-1:0] work;
  logic [3:0]       rem_q;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [4:0]       trial;
  logic             qbit;

  assign trial = {rem_q, work[VAL_W-1]};
  assign qbit  = (trial >= 5'd10);

  always_ff @(posedge clk) begin
    if (rst) begin
      work  <= '0;
      rem_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !run) begin
        work  <= dividend;
        rem_q <= '0;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        rem_q <= qbit ? 4'(trial - 5'd10) : trial[3:0];
        work  <= {work[VAL_W-2:0], qbit};
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(VAL_W-1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = work;
  assign remainder = rem_q;

  // R2
  rem_decimal_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (remainder <= 4'd9));

  // R7
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run));
endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcd_store_pkg::*;
#(
  parameter int MAG_W     = 64,
  parameter int NUM_BYTES = 10,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sign_in,
  input  logic [MAG_W-1:0]  mag_in,
  output logic              div_go,
  output logic [MAG_W-1:0]  div_val,
  input  logic              div_done,
  input  logic [MAG_W-1:0]  div_quot,
  input  logic [3:0]        div_rem,
  output logic              busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BYTES-1);

  seq_state_t        state;
  logic [MAG_W-1:0]  val;
  logic              sign_q;
  logic [ADDR_W-1:0] byte_idx;
  logic              hi_phase;
  logic [3:0]        lo_nib;

  assign div_go  = (state == ST_LAUNCH);
  assign div_val = val;
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      val      <= '0;
      sign_q   <= 1'b0;
      byte_idx <= '0;
      hi_phase <= 1'b0;
      lo_nib   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            val      <= mag_in;
            sign_q   <= sign_in;
            byte_idx <= '0;
            hi_phase <= 1'b0;
            state    <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            val <= div_quot;
            if (!hi_phase && byte_idx != LAST) begin
              lo_nib   <= div_rem;
              hi_phase <= 1'b1;
              state    <= ST_LAUNCH;
            end else begin
              wr_valid <= 1'b1;
              wr_addr  <= byte_idx;
              hi_phase <= 1'b0;
              if (byte_idx == LAST) begin
                wr_data <= {sign_q, 3'b000, div_rem};
                state   <= ST_FINISH;
              end else begin
                wr_data  <= {div_rem, lo_nib};
                byte_idx <= byte_idx + 1'b1;
                state    <= ST_LAUNCH;
              end
            end
          end
        end
        ST_FINISH: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R6
  done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_valid) && $past(wr_addr) == LAST));

  // R4
  top_byte_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == LAST) |-> (wr_data[6:4] == 3'b000));

  // R2
  nibble_decimal_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_data[3:0] <= 4'd9 && (wr_addr == LAST || wr_data[7:4] <= 4'd9)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_FINISH) |=> busy);
endmodule

// File: rtl/bcd_store.sv
module bcd_store #(
  parameter int MAG_W     = 64,
  parameter int NUM_BYTES = 10,
  parameter int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sign_in,
  input  logic [MAG_W-1:0]  mag_in,
  output logic              busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done
);
  logic             div_go;
  logic             div_done;
  logic [MAG_W-1:0] div_val;
  logic [MAG_W-1:0] div_quot;
  logic [3:0]       div_rem;

  bcd_seq #(
    .MAG_W(MAG_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .sign_in(sign_in), .mag_in(mag_in),
    .div_go(div_go), .div_val(div_val), .div_done(div_done),
    .div_quot(div_quot), .div_rem(div_rem), .busy(busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  bcd_div10 #(.VAL_W(MAG_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_val),
    .done(div_done), .quotient(div_quot), .remainder(div_rem)
  );
endmodule

// File: tb/bcd_store_test.sv
module bcd_store_test;
  localparam int MAG_W = 64;
  localparam int NB    = 10;
  localparam int AW    = 4;
  localparam int D     = MAG_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sign_in = 1'b0;
  logic [MAG_W-1:0] mag_in = '0;
  logic busy, wr_valid, done;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  bcd_store #(.MAG_W(MAG_W), .NUM_BYTES(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .sign_in(sign_in), .mag_in(mag_in),
    .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [MAG_W-1:0] m, input logic s, input int k);
    logic [3:0] dg [19];
    logic [MAG_W-1:0] r = m;
    for (int i = 0; i < 19; i++) begin
      dg[i] = 4'(r % 10);
      r = r / 10;
    end
    if (k == NB-1) return {s, 3'b000, dg[18]};
    return {dg[2*k+1], dg[2*k]};
  endfunction

  // Runs one conversion; optionally injects a second start at t=100.
  task automatic run_case(input logic s, input logic [MAG_W-1:0] m, input bit inject);
    int t = 0;
    int nwr = 0;
    bit seen_done = 1'b0;
    @(negedge clk);
    sign_in = s; mag_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; sign_in = 1'b0; mag_in = '0;
    check("R9 busy after start", busy, 1);
    while (!seen_done && t < 3000) begin
      @(negedge clk);
      t++;
      if (inject && t == 100) begin
        start = 1'b1; sign_in = ~s; mag_in = 64'd5555555555555555555;
      end else begin
        start = 1'b0; sign_in = 1'b0; mag_in = '0;
      end
      if (wr_valid) begin
        check("R5 offset order", longint'(wr_addr), nwr);
        // R1 R2 R3 R4 R8
        check(nwr == NB-1 ? "R4/R1 top byte" : "R2/R3 digit byte",
              longint'(wr_data), longint'(exp_byte(m, s, nwr)));
        check("R7 write timing", t, (nwr == NB-1) ? 19*D : 2*D*(nwr+1));
        nwr++;
      end
      if (done) begin
        seen_done = 1'b1;
        check("R6 done timing", t, 19*D + 1);
        check("R9 busy low at done", busy, 0);
      end
    end
    check("R5 write count", nwr, NB);
    check("R6 done seen", seen_done, 1);
    @(negedge clk);
    check("R6 done single cycle", done, 0);
    check("R5 no extra strobe", wr_valid, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset busy", busy, 0);
    check("R5 reset strobe", wr_valid, 0);
    check("R6 reset done", done, 0);
    rst = 1'b0;
  endtask

  initial begin
    test_reset();
    run_case(1'b0, 64'd0, 1'b0);                         // R2 zero
    run_case(1'b1, 64'd1234567890123456789, 1'b0);       // R1 R3 negative
    run_case(1'b0, 64'd9999999999999999999, 1'b0);       // R4 nineteen nines
    run_case(1'b1, 64'd0, 1'b0);                         // R1 negative zero
    run_case(1'b0, 64'd1000000000000000007, 1'b1);       // R8 second start
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule